// File: doc/BRIEF.md
# Flow-through synchronous SRAM model

A synthesizable behavioural model of a synchronous SRAM that needs no idle cycles between reads and writes. Commands, addresses, chip selects and per-byte write enables are captured on rising clock edges while the active-low clock enable is low. Read data comes straight out of the array in the cycle after the edge that presented the address, with no output register. Write data follows its command by one qualified edge. A two-bit burst counter steps the low address bits in linear or interleaved order.

The bidirectional data bus is split into a data-in bus, a data-out bus and an output-valid flag so that the model can be synthesized. Each word holds four bytes plus one parity bit per byte. A sleep input freezes the model and keeps the array contents.

Top module: `ft_sram`

## Requirements
- R1: At a rising edge with `cen_n` high, nothing is sampled, no write takes place and the access state is held. Whatever was being driven on `dout` keeps being driven.
- R2: A load selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A load with any other combination deselects it.
- R3: A qualified edge with `ld_n`=0 on a selected device starts an access at `addr`. For a read, the word at that address appears on `dout` with `dout_vld`=1 during the next cycle.
- R4: A qualified edge with `ld_n`=1 during an access advances a 2-bit counter k, which starts at 0 on the load. Address bits [1:0] are base[1:0]+k (mod 4) when `linear`=1 and base[1:0] XOR k when `linear`=0. The upper bits stay fixed.
- R5: An edge with `ld_n`=1 while the device is deselected starts no access, and the outputs stay off.
- R6: For a write (`wr_n`=0 at the load), the write data is taken from `din` at the next qualified edge. `bw_n` is sampled with each command edge and applies to that beat. When `bw_n[i]`=0, byte `din[8i+7:8i]` and its parity bit `din[32+i]` are written. When `bw_n[i]`=1, both are left unchanged.
- R7: `dout_vld` is 0 while `oe_n` is 1, during the data cycle of a write, and in every cycle after an edge that deselects the device. `dout` reads zero whenever `dout_vld` is 0.
- R8: While `sleep` is 1, edges are ignored, the outputs are off and the array keeps its contents.
- R9: A read of a location at the edge right after a write to it returns the newly written bytes together with the old unwritten bytes.
- R10: After reset no access is active and `dout_vld` is 0.
- R11: Reads, writes and bursts may follow each other on consecutive edges with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the access state |
| cen_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_n | input | 1 | Active-low write command |
| bw_n | input | 4 | Active-low byte write enables |
| addr | input | AW | Word address |
| linear | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| sleep | input | 1 | Freeze request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data: bytes [31:0], parity [35:32] |
| dout | output | 36 | Read data |
| dout_vld | output | 1 | Bus-drive flag |

## Verification
The bench goes after burst start offset 1, where linear order (1,2,3,0) and interleaved order (1,0,3,2) differ. A swapped or missing order would read the wrong words. It stalls writes with the clock enable, so that a design which writes on a masked edge commits the wrong data. It checks partial byte writes, so that a design ignoring a lane's parity bit corrupts the parity. It also covers a read right after a write, advances while deselected, and each chip select failing on its own. A design getting these wrong would return stale bytes, start phantom accesses or drive the bus while deselected.

// File: rtl/ft_sram.sv
module ft_sram #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 9 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          cs1_n,
  input  logic          cs2,
  input  logic          cs3_n,
  input  logic          ld_n,
  input  logic          wr_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  logic          linear,
  input  logic          sleep,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);

  logic [DW-1:0]    mem [DEPTH];
  logic             act, is_wr;
  logic [AW-1:0]    base;
  logic [1:0]       beat;
  logic [LANES-1:0] lane_n;

  wire go     = !cen_n && !sleep;
  wire sel    = !cs1_n && cs2 && !cs3_n;
  wire [1:0] lo = linear ? base[1:0] + beat : base[1:0] ^ beat;
  wire [AW-1:0] cur = {base[AW-1:2], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      is_wr  <= 1'b0;
      base   <= '0;
      beat   <= '0;
      lane_n <= '1;
    end else if (go) begin
      if (!ld_n) begin
        act    <= sel;
        is_wr  <= sel && !wr_n;
        base   <= addr;
        beat   <= '0;
        lane_n <= bw_n;
      end else if (act) begin
        beat   <= beat + 2'd1;
        lane_n <= bw_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go && act && is_wr)
      for (int i = 0; i < LANES; i++)
        if (!lane_n[i]) begin
          mem[cur][8*i +: 8]   <= din[8*i +: 8];
          mem[cur][8*LANES+i]  <= din[8*LANES+i];
        end
  end

  assign dout_vld = !oe_n && !sleep && act && !is_wr;
  assign dout     = dout_vld ? mem[cur] : '0;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable({act, is_wr, base, beat})); // R1
  AST_BAD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && !sel) |=> !dout_vld); // R2
  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && sel) |=> (base == $past(addr) && beat == 2'd0)); // R3
  AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ld_n && !act) |=> !act); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !ld_n && sel && !wr_n) |=> !dout_vld); // R7
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable({act, is_wr, base, beat})); // R8
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_vld); // R7

endmodule

// File: tb/ft_sram_tb.sv
`timescale 1ns/1ps
module ft_sram_tb;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic cen_n = 1, cs1_n = 1, cs2 = 0, cs3_n = 1, ld_n = 1, wr_n = 1;
  logic [3:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic linear = 1, sleep = 0, oe_n = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_vld;

  ft_sram #(.DEPTH(DEPTH), .LANES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_n(ld_n), .wr_n(wr_n), .bw_n(bw_n), .addr(addr),
    .linear(linear), .sleep(sleep), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_vld(dout_vld));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic m_act = 0, m_wr = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0] m_k = '0;
  logic [3:0] m_bw = '1;

  function automatic logic [AW-1:0] eff_addr();
    logic [1:0] lo;
    lo = linear ? m_base[1:0] + m_k : m_base[1:0] ^ m_k;
    return {m_base[AW-1:2], lo};
  endfunction

  function automatic logic exp_vld();
    return !oe_n && !sleep && m_act && !m_wr;
  endfunction

  function automatic logic [DW-1:0] exp_data();
    return exp_vld() ? ref_mem[eff_addr()] : '0;
  endfunction

  task automatic model_edge();
    if (!cen_n && !sleep) begin
      if (m_act && m_wr)
        for (int i = 0; i < 4; i++)
          if (!m_bw[i]) begin
            ref_mem[eff_addr()][8*i +: 8] = din[8*i +: 8];
            ref_mem[eff_addr()][32+i]     = din[32+i];
          end
      if (!ld_n) begin
        m_act = !cs1_n && cs2 && !cs3_n;
        m_wr  = m_act && !wr_n;
        m_base = addr; m_k = 0; m_bw = bw_n;
      end else if (m_act) begin
        m_k = m_k + 1; m_bw = bw_n;
      end
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (dout_vld !== exp_vld() || dout !== exp_data()) begin
      errors++;
      $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h",
               tag, dout_vld, dout, exp_vld(), exp_data());
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic cmd(input logic ld, input logic wr, input logic [3:0] bw,
                     input logic [AW-1:0] a);
    cen_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0;
    ld_n = ld; wr_n = wr; bw_n = bw; addr = a;
    din = {$urandom(), $urandom()};
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: vld=%0b dout=%h expected vld=x dout=x", dout_vld, dout);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R10");
    rst_n = 1;
    @(negedge clk);
    check("R10");

    // prefill, pipelined writes: no idle cycle (R11)
    for (int i = 0; i <= DEPTH; i++) begin
      if (i < DEPTH) cmd(0, 0, 4'h0, i[AW-1:0]);
      else begin cmd(0, 1, 4'hf, 0); cs2 = 0; end
      tick("R11");
    end

    cmd(0, 1, 4'hf, 8'd5); tick("R3");
    cmd(0, 1, 4'hf, 8'd6); tick("R3");

    // chip select combinations, each failing alone
    cmd(0, 1, 4'hf, 8'd7); cs1_n = 1; tick("R2");
    cmd(0, 1, 4'hf, 8'd7); cs2 = 0;   tick("R2");
    cmd(0, 1, 4'hf, 8'd7); cs3_n = 1; tick("R2");
    cmd(1, 1, 4'hf, 8'd7); tick("R5");
    cmd(1, 1, 4'hf, 8'd7); tick("R5");

    // bursts from offset 1
    linear = 1;
    cmd(0, 1, 4'hf, 8'd9); tick("R4");
    for (int b = 0; b < 4; b++) begin cmd(1, 1, 4'hf, 8'd0); tick("R4"); end
    cmd(0, 1, 4'hf, 8'd0); cs2 = 0; tick("R7");
    linear = 0;
    cmd(0, 1, 4'hf, 8'd9); tick("R4");
    for (int b = 0; b < 4; b++) begin cmd(1, 1, 4'hf, 8'd0); tick("R4"); end

    // partial byte write, then read at next edge
    cmd(0, 0, 4'b1010, 8'd20); tick("R7");
    cmd(0, 1, 4'hf, 8'd20);    tick("R9");
    cmd(0, 1, 4'hf, 8'd20);    tick("R6");

    // stalled write data phase
    cmd(0, 0, 4'b0110, 8'd21); tick("R7");
    cmd(0, 1, 4'hf, 8'd21); cen_n = 1; tick("R1");
    cmd(0, 1, 4'hf, 8'd21); cen_n = 1; tick("R1");
    cmd(0, 1, 4'hf, 8'd21); tick("R6");
    cmd(0, 1, 4'hf, 8'd21); cen_n = 1; tick("R1");

    // output enable high during a read
    cmd(0, 1, 4'hf, 8'd22); oe_n = 1; tick("R7");
    oe_n = 0; #1; check("R3");

    // sleep
    cmd(0, 0, 4'h0, 8'd23); sleep = 1; tick("R8");
    tick("R8");
    sleep = 0;
    cmd(0, 1, 4'hf, 8'd23); tick("R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) linear = ~linear;
      cmd($urandom_range(0, 9) < 4, $urandom_range(0, 1), $urandom(),
          $urandom_range(0, 15));
      cen_n = $urandom_range(0, 9) < 2;
      cs1_n = $urandom_range(0, 19) == 0;
      cs2   = $urandom_range(0, 19) != 0;
      cs3_n = $urandom_range(0, 19) == 0;
      oe_n  = $urandom_range(0, 9) == 0;
      sleep = $urandom_range(0, 39) == 0;
      tick("R11");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule